// File: doc/BRIEF.md
# I2C Byte Data Path with Double-Buffered Transmit

This block is the byte-wide data path of an I2C controller. Software writes a byte into a holding buffer. A serial shift register then moves that byte onto SDA, most significant bit first, and gathers incoming bits from SDA into the same register. The bus-level controller, which is outside this block, handles START/STOP generation, acknowledge, clock generation and arbitration. It reports the bus condition and the software actions to this block as strobes: bus busy, interrupt clear, repeated-start request and slave address match.

The holding buffer decouples software from the byte that is currently on the wire. When the bus is idle, a write reaches the shift register straight away, so the first byte is ready at START. When the bus is busy, a write fills only the holding buffer. The shift register then takes that byte only on a protocol event. In slave mode those events are blocked until the own address has matched. A read returns the live shift register and not the byte last written, so received data is meaningful only while the transfer-complete flag is set.

Top module: `i2c_dsr`

## Requirements
- R1: After reset, `rd_data_o` is 0x00, the holding buffer is 0x00, `sda_o` is 1 and `byte_done_o` is 0.
- R2: A write while `bus_busy_i`=0 puts `wr_data_i` into both the holding buffer and the shift register on that edge. The bit count restarts. This load wins over a `sample_en_i` in the same cycle.
- R3: A write while `bus_busy_i`=1 updates only the holding buffer. The shift register, and so `rd_data_o`, is not changed by it.
- R4: While busy in master mode (`slave_mode_i`=0), an `int_clr_i` pulse copies the holding buffer into the shift register. The value copied is the one the buffer held before any write in the same cycle.
- R5: While busy in master mode, an `rstart_req_i` pulse copies the holding buffer into the shift register in the same way as R4.
- R6: `int_clr_i` and `rstart_req_i` in the same cycle give one load. Exactly 8 further samples then complete the next byte.
- R7: While busy in slave mode, `int_clr_i` and `rstart_req_i` do not load until an address match has been seen since the bus became busy. An `addr_match_i` pulse itself loads the holding buffer and records the match. The record clears while the bus is idle.
- R8: With no load in the cycle, a `sample_en_i` pulse shifts the register left by one and places `sda_i` in bit 0.
- R9: `byte_done_o` is high for exactly one cycle, the cycle after the 8th sample since the last load or the last completed byte.
- R10: `sda_o` takes bit 7 of the shift register only on a `shift_en_i` pulse and holds at all other times.
- R11: `rd_data_o` always shows the shift register. `rd_valid_o` follows `int_flag_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 8 | Software write data |
| rd_data_o | output | 8 | Live shift register contents |
| rd_valid_o | output | 1 | Read data is meaningful (interrupt flag set) |
| bus_busy_i | input | 1 | Bus is between START and STOP |
| int_flag_i | input | 1 | Transfer-complete interrupt flag |
| int_clr_i | input | 1 | Software clears the interrupt flag |
| rstart_req_i | input | 1 | Software requests a repeated start |
| slave_mode_i | input | 1 | Controller operates as slave |
| addr_match_i | input | 1 | Own slave address matched |
| shift_en_i | input | 1 | Drive next bit (SCL low) |
| sample_en_i | input | 1 | Sample SDA (SCL high) |
| sda_i | input | 1 | SDA line input |
| sda_o | output | 1 | SDA output bit |
| byte_done_o | output | 1 | Eight bits transferred |

## Verification
The bench builds the block at its default width of 8 bits. At this width a full byte is clocked through in eight sample pulses, so the exact cycle of `byte_done_o` can be checked after each kind of load. The directed scenarios cover idle and busy writes, both busy-load triggers alone and together, blocking in slave mode until address match, and a load meeting a sample in the same cycle. The bench follows `sda_o` bit by bit as the byte is shifted out.

// File: rtl/i2c_dsr_pkg.sv
package i2c_dsr_pkg;
  typedef enum logic [1:0] {
    LD_NONE   = 2'd0,
    LD_DIRECT = 2'd1,
    LD_HOLD   = 2'd2
  } ld_src_e;
endpackage

// File: rtl/i2c_dsr_hold.sv
module i2c_dsr_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] hold_o
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (wr_en_i) hold_q <= wr_data_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/i2c_dsr_load_ctrl.sv
module i2c_dsr_load_ctrl
  import i2c_dsr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_en_i,
  input  logic    bus_busy_i,
  input  logic    int_clr_i,
  input  logic    rstart_req_i,
  input  logic    slave_mode_i,
  input  logic    addr_match_i,
  output ld_src_e ld_src_o,
  output logic    matched_o
);
  logic matched_q;
  logic evt_sw;
  logic evt_addr;

  // software events are gated in slave mode until the address is known
  assign evt_sw   = bus_busy_i && (int_clr_i || rstart_req_i) && (!slave_mode_i || matched_q);
  assign evt_addr = bus_busy_i && slave_mode_i && addr_match_i;

  always_comb begin
    if (!bus_busy_i && wr_en_i)   ld_src_o = LD_DIRECT;
    else if (evt_sw || evt_addr)  ld_src_o = LD_HOLD;
    else                          ld_src_o = LD_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         matched_q <= 1'b0;
    else if (!bus_busy_i) matched_q <= 1'b0;
    else if (evt_addr)   matched_q <= 1'b1;
  end

  assign matched_o = matched_q;
endmodule

// File: rtl/i2c_dsr_shifter.sv
module i2c_dsr_shifter
  import i2c_dsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ld_src_e           ld_src_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              shift_en_i,
  input  logic              sample_en_i,
  input  logic              sda_i,
  output logic [DATA_W-1:0] sreg_o,
  output logic              sda_o
);
  logic [DATA_W-1:0] sreg_q;
  logic              sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
    end else begin
      unique case (ld_src_i)
        LD_DIRECT: sreg_q <= wr_data_i;
        LD_HOLD:   sreg_q <= hold_i;
        default:   if (sample_en_i) sreg_q <= {sreg_q[DATA_W-2:0], sda_i};
      endcase
    end
  end

  // SDA changes only while SCL is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sda_q <= 1'b1;
    else if (shift_en_i) sda_q <= sreg_q[DATA_W-1];
  end

  assign sreg_o = sreg_q;
  assign sda_o  = sda_q;
endmodule

// File: rtl/i2c_dsr_bitcnt.sv
module i2c_dsr_bitcnt
  import i2c_dsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ld_src_e ld_src_i,
  input  logic    sample_en_i,
  output logic    done_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (ld_src_i != LD_NONE) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (sample_en_i) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/i2c_dsr.sv
module i2c_dsr
  import i2c_dsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic              bus_busy_i,
  input  logic              int_flag_i,
  input  logic              int_clr_i,
  input  logic              rstart_req_i,
  input  logic              slave_mode_i,
  input  logic              addr_match_i,
  input  logic              shift_en_i,
  input  logic              sample_en_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              byte_done_o
);
  ld_src_e           ld_src;
  logic              matched;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] sreg;

  i2c_dsr_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .hold_o   (hold_q)
  );

  i2c_dsr_load_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .bus_busy_i  (bus_busy_i),
    .int_clr_i   (int_clr_i),
    .rstart_req_i(rstart_req_i),
    .slave_mode_i(slave_mode_i),
    .addr_match_i(addr_match_i),
    .ld_src_o    (ld_src),
    .matched_o   (matched)
  );

  i2c_dsr_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_src_i   (ld_src),
    .wr_data_i  (wr_data_i),
    .hold_i     (hold_q),
    .shift_en_i (shift_en_i),
    .sample_en_i(sample_en_i),
    .sda_i      (sda_i),
    .sreg_o     (sreg),
    .sda_o      (sda_o)
  );

  i2c_dsr_bitcnt #(.DATA_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_src_i   (ld_src),
    .sample_en_i(sample_en_i),
    .done_o     (byte_done_o)
  );

  assign rd_data_o  = sreg;
  assign rd_valid_o = int_flag_i;
endmodule

// File: rtl/i2c_dsr_chk.sv
module i2c_dsr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              bus_busy_i,
  input logic              int_clr_i,
  input logic              rstart_req_i,
  input logic              slave_mode_i,
  input logic              addr_match_i,
  input logic              shift_en_i,
  input logic              sample_en_i,
  input logic              sda_i,
  input logic              sda_o,
  input logic              byte_done_o,
  input logic [DATA_W-1:0] hold_i,
  input logic              matched_i
);
  p_idle_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_busy_i && wr_en_i |=> rd_data_o == $past(wr_data_i));

  p_busy_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_busy_i && wr_en_i && !int_clr_i && !rstart_req_i && !addr_match_i && !sample_en_i
    |=> rd_data_o == $past(rd_data_o));

  p_clr_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_busy_i && !slave_mode_i && int_clr_i |=> rd_data_o == $past(hold_i));

  p_rstart_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_busy_i && !slave_mode_i && rstart_req_i |=> rd_data_o == $past(hold_i));

  p_slave_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_busy_i && slave_mode_i && !matched_i && !addr_match_i && !sample_en_i
    |=> rd_data_o == $past(rd_data_o));

  p_addr_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_busy_i && slave_mode_i && addr_match_i |=> rd_data_o == $past(hold_i));

  p_sample_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_en_i && !wr_en_i && !int_clr_i && !rstart_req_i && !addr_match_i
    |=> rd_data_o == {$past(rd_data_o[DATA_W-2:0]), $past(sda_i)});

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> !byte_done_o);

  p_sda_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(sda_o));

  p_sda_msb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> sda_o == $past(rd_data_o[DATA_W-1]));
endmodule

bind i2c_dsr i2c_dsr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .bus_busy_i  (bus_busy_i),
  .int_clr_i   (int_clr_i),
  .rstart_req_i(rstart_req_i),
  .slave_mode_i(slave_mode_i),
  .addr_match_i(addr_match_i),
  .shift_en_i  (shift_en_i),
  .sample_en_i (sample_en_i),
  .sda_i       (sda_i),
  .sda_o       (sda_o),
  .byte_done_o (byte_done_o),
  .hold_i      (hold_q),
  .matched_i   (matched)
);

// File: tb/tb_i2c_dsr.sv
module tb_i2c_dsr;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid;
  logic         busy = 1'b0;
  logic         int_flag = 1'b0;
  logic         int_clr = 1'b0;
  logic         rstart = 1'b0;
  logic         slave = 1'b0;
  logic         amatch = 1'b0;
  logic         shift_en = 1'b0;
  logic         sample_en = 1'b0;
  logic         sda_in = 1'b0;
  logic         sda_out;
  logic         done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dsr #(.DATA_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .bus_busy_i(busy),
    .int_flag_i(int_flag), .int_clr_i(int_clr), .rstart_req_i(rstart),
    .slave_mode_i(slave), .addr_match_i(amatch), .shift_en_i(shift_en),
    .sample_en_i(sample_en), .sda_i(sda_in), .sda_o(sda_out), .byte_done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs are set after a falling edge and held for one rising edge
  task automatic step();
    @(negedge clk);
    wr_en = 0; int_clr = 0; rstart = 0; amatch = 0; shift_en = 0; sample_en = 0;
  endtask

  task automatic wr(input logic [W-1:0] d);
    wr_en = 1; wr_data = d; step();
  endtask

  task automatic sample(input logic b);
    sample_en = 1; sda_in = b; step();
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 0);
    chk("R1 sda_o", sda_out, 1);
    chk("R1 byte_done", done, 0);
    busy = 1; int_clr = 1; step();
    chk("R1 holding zero", rd_data, 0);
    busy = 0; step();
  endtask

  task automatic t_idle_write();
    wr(8'hA5);
    chk("R2 idle write", rd_data, 8'hA5);
    chk("R10 no shift_en", sda_out, 1);
    sample(1'b0);
    chk("R8 shift in 0", rd_data, 8'h4A);
    chk("R10 hold after sample", sda_out, 1);
    shift_en = 1; step();
    chk("R10 msb out", sda_out, 0);
    int_flag = 1; #1;
    chk("R11 rd_valid", rd_valid, 1);
    int_flag = 0; #1;
    chk("R11 rd_valid low", rd_valid, 0);
  endtask

  task automatic t_busy_clr();
    busy = 1; step();
    wr(8'h3C);
    chk("R3 busy write no effect", rd_data, 8'h4A);
    int_clr = 1; wr_en = 1; wr_data = 8'h11; step();
    chk("R4 clr loads old holding", rd_data, 8'h3C);
    int_clr = 1; step();
    chk("R4 clr loads new holding", rd_data, 8'h11);
  endtask

  task automatic t_rstart();
    wr(8'h81);
    chk("R3 busy write no effect", rd_data, 8'h11);
    rstart = 1; step();
    chk("R5 rstart load", rd_data, 8'h81);
    shift_en = 1; step();
    chk("R10 msb of 81", sda_out, 1);
  endtask

  task automatic t_both();
    logic [W-1:0] pat = 8'hC3;
    wr(8'h7E);
    sample(1'b1); // leave the bit count mid-byte
    int_clr = 1; rstart = 1; step();
    chk("R6 single load", rd_data, 8'h7E);
    for (int i = W-1; i >= 1; i--) sample(pat[i]);
    chk("R9 no done after 7", done, 0);
    sample(pat[0]);
    chk("R9 done after 8", done, 1);
    chk("R8 received byte", rd_data, 8'hC3);
    step();
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic t_slave();
    busy = 0; step();
    slave = 1; busy = 1; step();
    wr(8'h5A);
    int_clr = 1; step();
    chk("R7 clr blocked", rd_data, 8'hC3);
    rstart = 1; step();
    chk("R7 rstart blocked", rd_data, 8'hC3);
    amatch = 1; step();
    chk("R7 match load", rd_data, 8'h5A);
    wr(8'h66);
    int_clr = 1; step();
    chk("R7 clr after match", rd_data, 8'h66);
    busy = 0; step();
    busy = 1; wr(8'h99);
    int_clr = 1; step();
    chk("R7 match cleared by idle", rd_data, 8'h66);
    slave = 0; busy = 0; step();
  endtask

  task automatic t_priority();
    wr_en = 1; wr_data = 8'h0F; sample_en = 1; sda_in = 1; step();
    chk("R2 write over sample", rd_data, 8'h0F);
    busy = 1; wr(8'hF0);
    int_clr = 1; sample_en = 1; sda_in = 1; step();
    chk("R8 load over sample", rd_data, 8'hF0);
    busy = 0; step();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        t_reset();
        t_idle_write();
        t_busy_clr();
        t_rstart();
        t_both();
        t_slave();
        t_priority();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule